// File: doc/BRIEF.md
# EPP Debug Mailbox Controller

This block sits behind the peripheral end of an IEEE 1284 EPP parallel port on a debug board. It gives a host PC three things. The first is a one-byte command and status register, reached through EPP address cycles. The second is a 2 KB byte buffer, streamed through EPP data cycles. The third is a set of three JTAG output pins, with the TDO return presented on a status line.

The buffer has independent write and read pointers, and each advances by one per data byte. The top bits of a command byte select one of four actions: load a pointer on a 32-byte block boundary, reset the host-side state, set or clear mailbox handshake flags, or latch the JTAG pins. The target side has its own byte port into the same buffer and its own controls on the handshake flags. Host and target use the flags to pace each 32-bit exchange with one request/acknowledge round.

All port inputs pass through two-flop synchronisers. The port's wait line goes high once a strobed cycle has been taken and drops after both strobes have returned high.

Top module: `epp_mailbox`

## Requirements
- R1: An EPP data write stores the byte at the write pointer, and the pointer then advances by one, wrapping from 2047 to 0.
- R2: An EPP data read returns the byte at the read pointer on `epp_dout` while `epp_wait` is high, and the read pointer then advances by one.
- R3: A command byte whose bits [7:6] are 2'b10 loads the write pointer with bits [5:0] times 32.
- R4: A command byte whose bits [7:6] are 2'b11 loads the read pointer with bits [5:0] times 32.
- R5: A command byte whose bits [7:5] are 3'b001 drives `jtag_tdi` from bit 2, `jtag_tms` from bit 1 and `jtag_tck` from bit 0. The pins hold until the next such command or a reset.
- R6: A command byte whose bits [7:5] are 3'b000 sets the outgoing request on bit 0 and the outgoing acknowledge on bit 1. It clears the incoming request on bit 2 and the incoming acknowledge on bit 3. An EPP address read returns {4'b0, in_ack, in_req, out_ack, out_req}.
- R7: The target sets the incoming flags with `tgt_in_req_set`/`tgt_in_ack_set` and clears them with `tgt_in_req_clr`/`tgt_in_ack_clr`, where set beats clear. It clears the outgoing flags with `tgt_out_req_clr`/`tgt_out_ack_clr`. A host command on the same flag in the same cycle takes priority.
- R8: A command byte whose bits [7:6] are 2'b01 returns both pointers, all four flags and the three JTAG pins to zero.
- R9: `paper_out` always presents the current `jtag_tdo` level.
- R10: `epp_wait` rises after a strobe is seen low and stays high while either strobe is low. It falls after both strobes are high. A strobe held low for many cycles performs exactly one action.
- R11: The target port writes `tgt_wdata` at `tgt_addr` when `tgt_we` is high, and returns the byte at `tgt_addr` on `tgt_rdata` one clock later.
- R12: After `rst_n` low, `epp_wait`, `epp_oe`, the JTAG pins, both pointers and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| epp_din | input | 8 | Byte from the host during write cycles |
| epp_dout | output | 8 | Byte to the host during read cycles |
| epp_oe | output | 1 | High while the block drives the port data lines |
| n_astb | input | 1 | Address strobe, active low |
| n_dstb | input | 1 | Data strobe, active low |
| n_write | input | 1 | Low for a host write cycle |
| epp_wait | output | 1 | High once the current cycle has been taken |
| paper_out | output | 1 | Status line that carries TDO |
| jtag_tck | output | 1 | JTAG clock pin |
| jtag_tms | output | 1 | JTAG mode select pin |
| jtag_tdi | output | 1 | JTAG data-in pin |
| jtag_tdo | input | 1 | JTAG data-out from the target |
| tgt_in_req_set | input | 1 | Target raises the incoming request |
| tgt_in_req_clr | input | 1 | Target drops the incoming request |
| tgt_in_ack_set | input | 1 | Target raises the incoming acknowledge |
| tgt_in_ack_clr | input | 1 | Target drops the incoming acknowledge |
| tgt_out_req_clr | input | 1 | Target drops the outgoing request |
| tgt_out_ack_clr | input | 1 | Target drops the outgoing acknowledge |
| tgt_we | input | 1 | Target buffer write enable |
| tgt_addr | input | 11 | Target buffer byte address |
| tgt_wdata | input | 8 | Target write byte |
| tgt_rdata | output | 8 | Target read byte, one cycle after the address |

## Verification
A vector table interleaves pointer loads, data bytes, JTAG patterns and flag commands. Reading bytes back after a block load shows whether the block field is scaled by 32 and whether each pointer advances independently of the other. Two distinct JTAG patterns with complementary bits show that each pin comes from its own command bit. Flag reads taken after each single-bit command show the bit positions apart.

Directed runs cover several further cases. A write that crosses the top of the buffer exposes the wrap. A strobe held low for several cycles must advance a pointer only once. Target-side writes and reads show whether the two ports share one storage. A soft reset followed by reads from block zero shows that every piece of host state returned to zero.

// File: rtl/epp_mailbox.sv
module epp_mailbox #(
  parameter int ADDR_W = 11,
  parameter int BLK_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        epp_din,
  output logic [7:0]        epp_dout,
  output logic              epp_oe,
  input  logic              n_astb,
  input  logic              n_dstb,
  input  logic              n_write,
  output logic              epp_wait,
  output logic              paper_out,
  output logic              jtag_tck,
  output logic              jtag_tms,
  output logic              jtag_tdi,
  input  logic              jtag_tdo,
  input  logic              tgt_in_req_set,
  input  logic              tgt_in_req_clr,
  input  logic              tgt_in_ack_set,
  input  logic              tgt_in_ack_clr,
  input  logic              tgt_out_req_clr,
  input  logic              tgt_out_ack_clr,
  input  logic              tgt_we,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [7:0]        tgt_wdata,
  output logic [7:0]        tgt_rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SEL_W = ADDR_W - BLK_W;

  logic [2:0] ctl_q1, ctl_q2;
  logic [7:0] din_q1, din_q2;
  logic [7:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic out_req, out_ack, in_req, in_ack;
  logic taken;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_q1 <= 3'b111; ctl_q2 <= 3'b111;
      din_q1 <= '0;     din_q2 <= '0;
    end else begin
      ctl_q1 <= {n_astb, n_dstb, n_write};
      ctl_q2 <= ctl_q1;
      din_q1 <= epp_din;
      din_q2 <= din_q1;
    end

  wire astb_lo = !ctl_q2[2];
  wire dstb_lo = !ctl_q2[1];
  wire wr_cyc  = !ctl_q2[0];
  wire take    = !taken && (astb_lo || dstb_lo);
  wire done    = taken && !astb_lo && !dstb_lo;
  wire cmd_wr  = take && astb_lo && wr_cyc;
  wire dat_wr  = take && !astb_lo && wr_cyc;
  wire dat_rd  = take && !astb_lo && !wr_cyc;
  wire h_rst   = cmd_wr && din_q2[7:6] == 2'b01;
  wire h_wp    = cmd_wr && din_q2[7:6] == 2'b10;
  wire h_rp    = cmd_wr && din_q2[7:6] == 2'b11;
  wire h_flag  = cmd_wr && din_q2[7:5] == 3'b000;
  wire h_jtag  = cmd_wr && din_q2[7:5] == 3'b001;
  wire [7:0] status = {4'b0, in_ack, in_req, out_ack, out_req};

  assign epp_wait  = taken;
  assign paper_out = jtag_tdo;

  always_ff @(posedge clk) begin
    if (dat_wr) mem[wr_ptr] <= din_q2;
    else if (tgt_we) mem[tgt_addr] <= tgt_wdata;
    tgt_rdata <= mem[tgt_addr];
    if (take) epp_dout <= astb_lo ? status : mem[rd_ptr];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      taken <= 1'b0;
      epp_oe <= 1'b0;
    end else if (take) begin
      taken <= 1'b1;
      epp_oe <= !wr_cyc;
    end else if (done) begin
      taken <= 1'b0;
      epp_oe <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0;
      {jtag_tdi, jtag_tms, jtag_tck} <= 3'b000;
    end else if (h_rst) begin
      wr_ptr <= '0; rd_ptr <= '0;
      {jtag_tdi, jtag_tms, jtag_tck} <= 3'b000;
    end else begin
      if (h_wp) wr_ptr <= {din_q2[SEL_W-1:0], {BLK_W{1'b0}}};
      else if (dat_wr) wr_ptr <= wr_ptr + 1'b1;
      if (h_rp) rd_ptr <= {din_q2[SEL_W-1:0], {BLK_W{1'b0}}};
      else if (dat_rd) rd_ptr <= rd_ptr + 1'b1;
      if (h_jtag) {jtag_tdi, jtag_tms, jtag_tck} <= din_q2[2:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {out_req, out_ack, in_req, in_ack} <= 4'b0000;
    end else if (h_rst) begin
      {out_req, out_ack, in_req, in_ack} <= 4'b0000;
    end else begin
      if (h_flag && din_q2[0]) out_req <= 1'b1;
      else if (tgt_out_req_clr) out_req <= 1'b0;
      if (h_flag && din_q2[1]) out_ack <= 1'b1;
      else if (tgt_out_ack_clr) out_ack <= 1'b0;
      if (h_flag && din_q2[2]) in_req <= 1'b0;
      else if (tgt_in_req_set) in_req <= 1'b1;
      else if (tgt_in_req_clr) in_req <= 1'b0;
      if (h_flag && din_q2[3]) in_ack <= 1'b0;
      else if (tgt_in_ack_set) in_ack <= 1'b1;
      else if (tgt_in_ack_clr) in_ack <= 1'b0;
    end
endmodule

// File: rtl/epp_mailbox_chk.sv
module epp_mailbox_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dat_wr,
  input logic              dat_rd,
  input logic              wp_load,
  input logic              rp_load,
  input logic              soft_rst,
  input logic              jtag_load,
  input logic              host_clr_in_req,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic [ADDR_W-1:0] rd_ptr,
  input logic [3:0]        flags,
  input logic [2:0]        pins,
  input logic              wait_o,
  input logic              strobes_hi
);
  a_r1_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> wr_ptr == $past(wr_ptr) + 1'b1);
  a_r1_wptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr && !wp_load && !soft_rst |=> $stable(wr_ptr));
  a_r2_rptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd |=> rd_ptr == $past(rd_ptr) + 1'b1);
  a_r4_rptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_rd && !rp_load && !soft_rst |=> $stable(rd_ptr));
  a_r5_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !jtag_load && !soft_rst |=> $stable(pins));
  a_r7_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr_in_req |=> !flags[2]);
  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> wr_ptr == '0 && rd_ptr == '0 && flags == 4'b0 && pins == 3'b0);
  a_r10_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o && !strobes_hi |=> wait_o);
  a_r10_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> !dat_wr && !dat_rd);
endmodule

bind epp_mailbox epp_mailbox_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .dat_wr(dat_wr), .dat_rd(dat_rd),
  .wp_load(h_wp), .rp_load(h_rp), .soft_rst(h_rst), .jtag_load(h_jtag),
  .host_clr_in_req(h_flag && din_q2[2]),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .flags({in_ack, in_req, out_ack, out_req}),
  .pins({jtag_tdi, jtag_tms, jtag_tck}),
  .wait_o(epp_wait), .strobes_hi(ctl_q2[2] && ctl_q2[1])
);

// File: tb/epp_mailbox_test.sv
module epp_mailbox_test;
  logic clk = 0, rst_n = 0;
  logic [7:0] epp_din = 0, epp_dout, tgt_wdata = 0, tgt_rdata;
  logic n_astb = 1, n_dstb = 1, n_write = 1;
  logic epp_oe, epp_wait, paper_out, jtag_tck, jtag_tms, jtag_tdi, jtag_tdo = 0;
  logic tirs = 0, tirc = 0, tias = 0, tiac = 0, torc = 0, toac = 0, tgt_we = 0;
  logic [10:0] tgt_addr = 0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  epp_mailbox uut (
    .clk(clk), .rst_n(rst_n), .epp_din(epp_din), .epp_dout(epp_dout), .epp_oe(epp_oe),
    .n_astb(n_astb), .n_dstb(n_dstb), .n_write(n_write), .epp_wait(epp_wait),
    .paper_out(paper_out), .jtag_tck(jtag_tck), .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi),
    .jtag_tdo(jtag_tdo), .tgt_in_req_set(tirs), .tgt_in_req_clr(tirc),
    .tgt_in_ack_set(tias), .tgt_in_ack_clr(tiac), .tgt_out_req_clr(torc),
    .tgt_out_ack_clr(toac), .tgt_we(tgt_we), .tgt_addr(tgt_addr),
    .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata));

  localparam logic [1:0] AW = 0, AR = 1, DW = 2, DR = 3;
  // {op, byte, expected read, expected {tdi,tms,tck}, requirement}
  localparam int NV = 19;
  localparam logic [24:0] VEC [NV] = '{
    {DW, 8'hA5, 8'h00, 3'b000, 4'd1},  // R1
    {AW, 8'h81, 8'h00, 3'b000, 4'd3},  // R3
    {DW, 8'h11, 8'h00, 3'b000, 4'd1},
    {DW, 8'h22, 8'h00, 3'b000, 4'd1},
    {AW, 8'hC1, 8'h00, 3'b000, 4'd4},  // R4
    {DR, 8'h00, 8'h11, 3'b000, 4'd2},  // R2
    {DR, 8'h00, 8'h22, 3'b000, 4'd2},
    {AW, 8'h25, 8'h00, 3'b101, 4'd5},  // R5
    {AW, 8'h3A, 8'h00, 3'b010, 4'd5},
    {AW, 8'h01, 8'h00, 3'b010, 4'd6},  // R6
    {AR, 8'h00, 8'h01, 3'b010, 4'd6},
    {AW, 8'h02, 8'h00, 3'b010, 4'd6},
    {AR, 8'h00, 8'h03, 3'b010, 4'd6},
    {AW, 8'h40, 8'h00, 3'b000, 4'd8},  // R8
    {AR, 8'h00, 8'h00, 3'b000, 4'd8},
    {DR, 8'h00, 8'hA5, 3'b000, 4'd8},
    {DW, 8'h5A, 8'h00, 3'b000, 4'd8},
    {AW, 8'hC0, 8'h00, 3'b000, 4'd8},
    {DR, 8'h00, 8'h5A, 3'b000, 4'd8}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic epp(input logic [1:0] op, input logic [7:0] val, input int hold,
                     output logic [7:0] rd);
    @(negedge clk);
    epp_din = val;
    n_write = (op == AW || op == DW) ? 1'b0 : 1'b1;
    if (op == AW || op == AR) n_astb = 0; else n_dstb = 0;
    do @(negedge clk); while (!epp_wait);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check("R10 wait held", {7'b0, epp_wait}, 8'h01);
    end
    rd = epp_dout;
    n_astb = 1; n_dstb = 1; n_write = 1;
    do @(negedge clk); while (epp_wait);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check("R12 wait/oe", {6'b0, epp_wait, epp_oe}, 8'h00);
    check("R12 pins", {5'b0, jtag_tdi, jtag_tms, jtag_tck}, 8'h00);
    epp(AR, 0, 0, rd);
    check("R12 flags", rd, 8'h00);

    for (int i = 0; i < NV; i++) begin
      epp(VEC[i][24:23], VEC[i][22:15], 0, rd);
      if (VEC[i][24:23] == AR || VEC[i][24:23] == DR)
        check($sformatf("R%0d vec %0d read", VEC[i][3:0], i), rd, VEC[i][14:7]);
      check($sformatf("R%0d vec %0d pins", VEC[i][3:0], i),
            {5'b0, jtag_tdi, jtag_tms, jtag_tck}, {5'b0, VEC[i][6:4]});
    end

    // R9 TDO to status line
    jtag_tdo = 1; #1 check("R9 tdo high", {7'b0, paper_out}, 8'h01);
    jtag_tdo = 0; #1 check("R9 tdo low", {7'b0, paper_out}, 8'h00);

    // R7 target flag controls
    @(negedge clk); tirs = 1; @(negedge clk); tirs = 0;
    epp(AR, 0, 0, rd); check("R7 in_req set", rd, 8'h04);
    @(negedge clk); tias = 1; tiac = 1; @(negedge clk); tias = 0; tiac = 0;
    epp(AR, 0, 0, rd); check("R7 set beats clear", rd, 8'h0C);
    epp(AW, 8'h04, 0, rd); epp(AR, 0, 0, rd); check("R6 clear in_req", rd, 8'h08);
    @(negedge clk); tiac = 1; @(negedge clk); tiac = 0;
    epp(AR, 0, 0, rd); check("R7 in_ack clr", rd, 8'h00);
    epp(AW, 8'h03, 0, rd);
    @(negedge clk); torc = 1; @(negedge clk); torc = 0;
    epp(AR, 0, 0, rd); check("R7 out_req clr", rd, 8'h02);
    @(negedge clk); toac = 1; @(negedge clk); toac = 0;
    epp(AR, 0, 0, rd); check("R7 out_ack clr", rd, 8'h00);

    // R10 long strobe gives one action
    epp(AW, 8'h84, 0, rd);
    epp(DW, 8'h33, 5, rd);
    epp(DW, 8'h44, 0, rd);
    epp(AW, 8'hC4, 0, rd);
    epp(DR, 0, 0, rd); check("R10 first byte", rd, 8'h33);
    epp(DR, 0, 0, rd); check("R10 second byte", rd, 8'h44);

    // R1 wrap at top of buffer, seen through R11 target port
    epp(AW, 8'hBF, 0, rd);
    for (int i = 0; i < 32; i++) epp(DW, 8'(i + 8'h60), 0, rd);
    epp(DW, 8'hEE, 0, rd);
    @(negedge clk); tgt_addr = 11'd2047; @(negedge clk); @(negedge clk);
    check("R1 top byte", tgt_rdata, 8'h7F);
    tgt_addr = 11'd0; @(negedge clk); @(negedge clk);
    check("R1 wrapped byte", tgt_rdata, 8'hEE);

    // R11 target write, host read
    tgt_addr = 11'd64; tgt_wdata = 8'h77; tgt_we = 1;
    @(negedge clk); tgt_we = 0;
    epp(AW, 8'hC2, 0, rd);
    epp(DR, 0, 0, rd); check("R11 target write", rd, 8'h77);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule